// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns the memory segments of one transfer into a table of 8-byte descriptors. A requester pulses `start` to open a build and selects the count-word encoding with `alt_mode`. It then offers segments one at a time as (address, length) pairs over a valid/ready handshake and flags the final segment with `seg_last`. The block writes two 32-bit words for each descriptor through a plain memory write port. The word at index 2k holds the base address of descriptor k, and the word at index 2k+1 holds its count word. A segment is cut into pieces so that no piece spans a 64 KiB-aligned address boundary.

When the stream ends, the block pulses `done` together with the number of descriptors written. If the table would have grown too large, `done_overflow` rises instead and the requester falls back to programmed I/O. If no descriptor was produced, `done_empty` rises. In the normal encoding, the last count word is written a second time with an end-of-table bit once the final segment has arrived. The alternate encoding stores a word count in the upper half of the count word and has no end mark.

A single state machine controls the build. Its states are ST_IDLE, ST_WAIT (ready for a segment), ST_ADDR (write the address word or detect overflow), ST_CNT (write the count word and advance), ST_MARK (rewrite the last count word), ST_DRAIN (discard segments after an overflow) and ST_DONE (report).

The transitions are as follows:
- `start` in any state goes to ST_WAIT.
- ST_IDLE stays put until `start`.
- From ST_WAIT, an accepted non-empty segment goes to ST_ADDR. An accepted empty final segment goes to ST_DONE, or to ST_MARK when descriptors exist in normal mode.
- From ST_ADDR, a full table goes to ST_DONE if the current segment is the final one, or to ST_DRAIN if it is not. Otherwise ST_ADDR goes to ST_CNT.
- From ST_CNT, bytes left in the segment return to ST_ADDR. A finished final segment goes to ST_MARK (normal mode) or ST_DONE (alternate mode). Any other finished segment returns to ST_WAIT.
- ST_MARK goes to ST_DONE.
- ST_DRAIN goes to ST_DONE when it accepts the final segment.
- ST_DONE goes to ST_IDLE.

Top module: `desc_table_builder`

## Requirements
- R1: Descriptor k is written as its base address at word index 2k, followed on the next cycle by its count word at word index 2k+1. Descriptors are numbered from 0 in the order their pieces are produced.
- R2: Each descriptor covers min(0x10000 - (address mod 0x10000), remaining bytes of the segment). The next descriptor starts at the address just past it, so no descriptor crosses a 64 KiB-aligned boundary.
- R3: In normal mode (`alt_mode`=0 at `start`), the count word is the byte count in bits 15:0, with 0 standing for 65536, and zero in bits 31:16 on its first write.
- R4: In normal mode, after the final segment has been processed and at least one descriptor exists, the last descriptor's count word is written again at its index with bit 31 set. No other word is written after it.
- R5: In alternate mode (`alt_mode`=1 at `start`), the count word is ((bytes/4) - 1) mod 65536 in bits 31:16 with zero in bits 15:0. No end-of-table rewrite takes place.
- R6: The table holds at most MAX_ENTRIES-1 descriptors. When another descriptor is needed, none is written and the build ends with `done_overflow`=1 and `done_count`=MAX_ENTRIES-1. Segments still to come are accepted and discarded up to and including the final one.
- R7: A build that produces no descriptor ends with `done_empty`=1, `done_count`=0 and no memory write.
- R8: A segment of length zero is accepted and produces no descriptor.
- R9: A `start` pulse in any state clears the descriptor count and the write index, so the next build writes from word index 0.
- R10: After reset, `seg_ready`, `tbl_we` and `done` are low. `done` is a one-cycle pulse carrying the result flags and count. `seg_ready` is never high in a cycle that writes memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new build; clears count and write index |
| alt_mode | input | 1 | Count-word encoding, sampled with `start` (1 = alternate) |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Block accepts a segment this cycle |
| seg_addr | input | 32 | Segment base address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Segment is the final one of the transfer |
| tbl_we | output | 1 | Descriptor memory write strobe |
| tbl_waddr | output | TW | Descriptor memory word index |
| tbl_wdata | output | 32 | Descriptor memory write data |
| done | output | 1 | One-cycle build-finished pulse |
| done_count | output | CW | Descriptors written, valid with `done` |
| done_overflow | output | 1 | Table full, fall back to programmed I/O |
| done_empty | output | 1 | No descriptor produced |

## Verification
A wrong remaining-length or address register shows up on the very next count or address word, because each piece is written within two cycles of being cut. A descriptor counter that drifts moves the word index of the next write, so the same compare catches it at once. A wrong held end-mark word or index shows up only in the final rewrite, one cycle before `done`. A state machine that misses overflow or emptiness is caught when `done` fires, through its flags and count, and through writes that appear after the table should have stopped.

// File: rtl/desc_tbl_pkg.sv
package desc_tbl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ADDR,
        ST_CNT,
        ST_MARK,
        ST_DRAIN,
        ST_DONE
    } bld_state_t;

    // Address span that one descriptor must stay inside, as a bit count.
    localparam int BND_BITS = 16;
    // Width of one piece's byte count (up to a full span).
    localparam int CHUNK_W  = BND_BITS + 1;
    // End-of-table flag in the count word, normal mode only.
    localparam logic [31:0] END_FLAG = 32'h8000_0000;

endpackage

// File: rtl/desc_chunk_split.sv
module desc_chunk_split
    import desc_tbl_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic [BND_BITS-1:0] addr_lo,
    input  logic [LEN_W-1:0]    remaining,
    output logic [CHUNK_W-1:0]  chunk
);

    logic [CHUNK_W-1:0] span;
    logic [LEN_W-1:0]   span_ext;

    always_comb begin
        span     = (CHUNK_W'(1) << BND_BITS) - CHUNK_W'(addr_lo);
        span_ext = LEN_W'(span);
        chunk    = (remaining < span_ext) ? CHUNK_W'(remaining) : span;
    end

endmodule

// File: rtl/desc_word_encode.sv
module desc_word_encode
    import desc_tbl_pkg::*;
(
    input  logic               alt,
    input  logic [CHUNK_W-1:0] nbytes,
    output logic [31:0]        word
);

    logic [15:0] quads_m1;

    always_comb begin
        quads_m1 = 16'(nbytes[CHUNK_W-1:2]) - 16'd1;
        if (alt)
            word = {quads_m1, 16'h0000};
        else
            word = {16'h0000, nbytes[15:0]};
    end

endmodule

// File: rtl/desc_table_builder.sv
module desc_table_builder
    import desc_tbl_pkg::*;
#(
    parameter int LEN_W       = 24,
    parameter int MAX_ENTRIES = 256,
    localparam int TW = $clog2(2 * MAX_ENTRIES),
    localparam int CW = $clog2(MAX_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             alt_mode,
    input  logic             seg_valid,
    output logic             seg_ready,
    input  logic [31:0]      seg_addr,
    input  logic [LEN_W-1:0] seg_len,
    input  logic             seg_last,
    output logic             tbl_we,
    output logic [TW-1:0]    tbl_waddr,
    output logic [31:0]      tbl_wdata,
    output logic             done,
    output logic [CW-1:0]    done_count,
    output logic             done_overflow,
    output logic             done_empty
);

    localparam logic [CW-1:0] FULL_AT = CW'(MAX_ENTRIES - 1);

    bld_state_t         state, state_nx;
    logic               alt_q;
    logic               last_q;
    logic               ovf_q;
    logic [31:0]        cur_addr;
    logic [LEN_W-1:0]   rem;
    logic [CW-1:0]      count;
    logic [CW-1:0]      last_idx;
    logic [31:0]        last_word;
    logic [CHUNK_W-1:0] chunk;
    logic [31:0]        cnt_word;
    logic               accept;
    logic               table_full;

    desc_chunk_split #(.LEN_W(LEN_W)) u_split (
        .addr_lo  (cur_addr[BND_BITS-1:0]),
        .remaining(rem),
        .chunk    (chunk)
    );

    desc_word_encode u_enc (
        .alt   (alt_q),
        .nbytes(chunk),
        .word  (cnt_word)
    );

    assign accept     = seg_ready && seg_valid;
    assign table_full = (count >= FULL_AT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Next state and outputs
    always_comb begin
        state_nx      = state;
        seg_ready     = 1'b0;
        tbl_we        = 1'b0;
        tbl_waddr     = '0;
        tbl_wdata     = '0;
        done          = 1'b0;
        done_count    = '0;
        done_overflow = 1'b0;
        done_empty    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WAIT: begin
                seg_ready = 1'b1;
                if (seg_valid) begin
                    if (seg_len != '0)
                        state_nx = ST_ADDR;
                    else if (seg_last)
                        state_nx = (count != '0 && !alt_q) ? ST_MARK : ST_DONE;
                end
            end
            ST_ADDR: begin
                if (table_full) begin
                    state_nx = last_q ? ST_DONE : ST_DRAIN;
                end else begin
                    tbl_we    = 1'b1;
                    tbl_waddr = TW'({count, 1'b0});
                    tbl_wdata = cur_addr;
                    state_nx  = ST_CNT;
                end
            end
            ST_CNT: begin
                tbl_we    = 1'b1;
                tbl_waddr = TW'({count, 1'b1});
                tbl_wdata = cnt_word;
                if (rem != LEN_W'(chunk))
                    state_nx = ST_ADDR;
                else if (last_q)
                    state_nx = alt_q ? ST_DONE : ST_MARK;
                else
                    state_nx = ST_WAIT;
            end
            ST_MARK: begin
                tbl_we    = 1'b1;
                tbl_waddr = TW'({last_idx, 1'b1});
                tbl_wdata = last_word | END_FLAG;
                state_nx  = ST_DONE;
            end
            ST_DRAIN: begin
                seg_ready = 1'b1;
                if (seg_valid && seg_last)
                    state_nx = ST_DONE;
            end
            ST_DONE: begin
                done          = 1'b1;
                done_count    = count;
                done_overflow = ovf_q;
                done_empty    = (count == '0) && !ovf_q;
                state_nx      = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
        if (start)
            state_nx = ST_WAIT;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alt_q     <= 1'b0;
            last_q    <= 1'b0;
            ovf_q     <= 1'b0;
            cur_addr  <= '0;
            rem       <= '0;
            count     <= '0;
            last_idx  <= '0;
            last_word <= '0;
        end else if (start) begin
            alt_q  <= alt_mode;
            ovf_q  <= 1'b0;
            count  <= '0;
            last_q <= 1'b0;
        end else begin
            if (state == ST_WAIT && accept) begin
                cur_addr <= seg_addr;
                rem      <= seg_len;
                last_q   <= seg_last;
            end
            if (state == ST_ADDR && table_full)
                ovf_q <= 1'b1;
            if (state == ST_CNT) begin
                cur_addr  <= cur_addr + 32'(chunk);
                rem       <= rem - LEN_W'(chunk);
                count     <= count + 1'b1;
                last_idx  <= count;
                last_word <= cnt_word;
            end
        end
    end

    // Assertions
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (32'(tbl_waddr) < 32'(2 * MAX_ENTRIES - 2)));

    p_no_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CNT) |-> ((CHUNK_W'(cur_addr[BND_BITS-1:0]) + chunk) <= (CHUNK_W'(1) << BND_BITS)));

    p_piece_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CNT) |-> (chunk != '0));

    p_mark_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MARK) |-> !alt_q);

    p_mark_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MARK) |-> ($past(state) == ST_CNT || $past(state) == ST_WAIT));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ready_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seg_ready |-> !tbl_we);

endmodule

// File: tb/desc_table_builder_tb.sv
module desc_table_builder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 24;
    localparam int MAXE       = 8;
    localparam int TW         = $clog2(2 * MAXE);
    localparam int CW         = $clog2(MAXE + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             alt_mode = 1'b0;
    logic             seg_valid = 1'b0;
    logic             seg_ready;
    logic [31:0]      seg_addr = '0;
    logic [LEN_W-1:0] seg_len = '0;
    logic             seg_last = 1'b0;
    logic             tbl_we;
    logic [TW-1:0]    tbl_waddr;
    logic [31:0]      tbl_wdata;
    logic             done;
    logic [CW-1:0]    done_count;
    logic             done_overflow;
    logic             done_empty;

    desc_table_builder #(.LEN_W(LEN_W), .MAX_ENTRIES(MAXE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .alt_mode(alt_mode),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last), .tbl_we(tbl_we),
        .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata), .done(done),
        .done_count(done_count), .done_overflow(done_overflow),
        .done_empty(done_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad   = 0;

    // Reference model state
    int unsigned exp_idx[$];
    logic [31:0] exp_dat[$];
    int          exp_kind[$];   // 0 address (R1), 1 count (R3/R5), 2 end mark (R4)
    int          m_cnt;
    bit          m_ovf;
    bit          m_alt;
    logic [31:0] m_last;
    bit          done_expected = 0;
    bit          done_seen = 0;

    function automatic logic [31:0] enc_word(int unsigned b, bit alt);
        logic [15:0] q;
        q = 16'((b >> 2) - 1);
        if (alt) return {q, 16'h0000};
        return {16'h0000, b[15:0]};
    endfunction

    task automatic model_seg(logic [31:0] a, int unsigned len);
        int unsigned span, ch;
        while (len > 0 && !m_ovf) begin
            span = 32'h10000 - (a & 32'hFFFF);   // R2 piece limit
            ch   = (len < span) ? len : span;
            if (m_cnt + 1 >= MAXE) begin
                m_ovf = 1;
            end else begin
                exp_idx.push_back(2 * m_cnt);     exp_dat.push_back(a); exp_kind.push_back(0);
                m_last = enc_word(ch, m_alt);
                exp_idx.push_back(2 * m_cnt + 1); exp_dat.push_back(m_last); exp_kind.push_back(1);
                a   = a + ch;
                len = len - ch;
                m_cnt++;
            end
        end
    endtask

    task automatic model_finish();
        if (!m_ovf && m_cnt > 0 && !m_alt) begin
            exp_idx.push_back(2 * (m_cnt - 1) + 1);
            exp_dat.push_back(m_last | 32'h8000_0000);
            exp_kind.push_back(2);
        end
    endtask

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare outputs with the model on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (tbl_we) begin
                if (exp_idx.size() == 0) begin
                    check(0, "R4 R6 R7 R8 unexpected write", {32'(tbl_waddr), tbl_wdata}, 64'h0);
                end else begin
                    string rq;
                    int unsigned ei;
                    logic [31:0] ed;
                    int ek;
                    ei = exp_idx.pop_front();
                    ed = exp_dat.pop_front();
                    ek = exp_kind.pop_front();
                    rq = (ek == 0) ? "R1 R2 address word" :
                         (ek == 2) ? "R4 end mark" :
                         (m_alt ? "R5 count word" : "R3 count word");
                    check(32'(tbl_waddr) == ei && tbl_wdata == ed, rq,
                          {32'(tbl_waddr), tbl_wdata}, {ei, ed});
                end
            end
            if (done) begin
                if (!done_expected) begin
                    check(0, "R10 unexpected done", 64'h1, 64'h0);
                end else begin
                    logic [CW-1:0] ec;
                    bit ee;
                    ec = CW'(m_cnt);
                    ee = (m_cnt == 0) && !m_ovf;
                    check(done_count == ec && done_overflow == m_ovf && done_empty == ee,
                          "R6 R7 R10 done result",
                          {32'(done_count), 30'h0, done_overflow, done_empty},
                          {32'(ec), 30'h0, m_ovf, ee});
                end
                done_expected = 0;
                done_seen     = 1;
            end
        end
    end

    task automatic start_build(bit alt);
        exp_idx.delete(); exp_dat.delete(); exp_kind.delete();
        m_cnt = 0; m_ovf = 0; m_alt = alt; m_last = '0;
        done_expected = 1; done_seen = 0;
        @(negedge clk);
        start = 1'b1; alt_mode = alt;
        @(negedge clk);
        start = 1'b0; alt_mode = 1'b0;
    endtask

    task automatic send_seg(logic [31:0] a, int unsigned len, bit last);
        model_seg(a, len);
        if (last) model_finish();
        @(negedge clk);
        seg_valid = 1'b1; seg_addr = a; seg_len = LEN_W'(len); seg_last = last;
        while (!seg_ready) @(negedge clk);
        @(negedge clk);
        seg_valid = 1'b0; seg_last = 1'b0;
    endtask

    task automatic wait_done();
        int k;
        k = 0;
        while (!done_seen && k < 3000) begin
            @(negedge clk);
            k++;
        end
        check(done_seen, "R10 done watchdog", {63'h0, done_seen}, 64'h1);
        check(exp_idx.size() == 0, "R1 R4 all writes issued", 64'(exp_idx.size()), 64'h0);
        done_seen = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL R10 global watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!seg_ready && !tbl_we && !done, "R10 reset outputs",
              {61'h0, seg_ready, tbl_we, done}, 64'h0);

        // R1 R3 R4 one small segment
        start_build(0);
        send_seg(32'h0000_1000, 32'h200, 1);
        wait_done();

        // R2 segment crossing a 64 KiB boundary
        start_build(0);
        send_seg(32'h0001_FF00, 32'h300, 1);
        wait_done();

        // R2 R3 full 64 KiB pieces encode as zero
        start_build(0);
        send_seg(32'h0000_8000, 32'h20000, 0);
        send_seg(32'h0020_0000, 32'h10000, 1);
        wait_done();

        // R8 zero-length segments in the stream, including the last
        start_build(0);
        send_seg(32'h0000_4000, 32'h40, 0);
        send_seg(32'h0000_9000, 32'h0, 0);
        send_seg(32'h0000_A000, 32'h80, 0);
        send_seg(32'h0000_B000, 32'h0, 1);
        wait_done();

        // R5 alternate encoding, no end mark
        start_build(1);
        send_seg(32'h0003_FFF0, 32'h20, 0);
        send_seg(32'h0004_0000, 32'h10000, 1);
        wait_done();

        // R7 empty build
        start_build(0);
        send_seg(32'h0000_0000, 32'h0, 1);
        wait_done();

        // R6 overflow inside the final segment
        start_build(0);
        send_seg(32'h0000_0000, 32'h80000, 1);
        wait_done();

        // R6 overflow then drain of further segments
        start_build(0);
        send_seg(32'h0010_0000, 32'h60000, 0);
        send_seg(32'h0020_0000, 32'h30000, 0);
        send_seg(32'h0030_0000, 32'h100, 0);
        send_seg(32'h0040_0000, 32'h100, 1);
        wait_done();

        // R9 restart abandons an open build; next build writes from index 0
        start_build(0);
        send_seg(32'h0000_5000, 32'h100, 0);
        repeat (10) @(negedge clk);
        check(exp_idx.size() == 0, "R9 abandoned build writes", 64'(exp_idx.size()), 64'h0);
        start_build(0);
        send_seg(32'h0000_6000, 32'h10, 0);
        send_seg(32'h0000_7000, 32'h20, 1);
        wait_done();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule